// File: doc/BRIEF.md
# Receive Byte Queue with Sticky Interrupt Flags

This block sits behind a pulse-width encoder in an infrared receiver. The encoder hands it one byte at a time together with a pulse that marks the end of a received packet. The block queues the bytes in a small first-in first-out store and collects three events into sticky flags: the queue holds more entries than a programmable level, a packet has ended, and a byte arrived while the queue was full. One interrupt line is the OR of each flag gated by its enable bit.

Software uses a plain register port. It writes the enable word, which also holds the level. It reads the status word, which holds the flags and the live fill count. It pops bytes one by one from the data register. A flag stays set until software writes a 1 to its bit.

Top module: `rx_fifo_irq`

## Requirements
- R1: After reset, the status word (offset 0x30) and the enable word (offset 0x2C) read as 0, the interrupt line is low and the queue is empty.
- R2: Each accepted byte is stored in arrival order. A read of offset 0x20 returns the oldest byte in bits [7:0] and removes it.
- R3: A read of offset 0x20 while the queue is empty returns 0 and leaves the fill count unchanged.
- R4: Status bits [8 +: CW] carry the current fill count, where CW = clog2(DEPTH+1), so a full queue reports DEPTH there.
- R5: A byte that arrives while the queue holds DEPTH entries is discarded and sets status bit 0 (overflow). This holds even if a pop happens in the same cycle.
- R6: A packet-end pulse sets status bit 1.
- R7: Status bit 4 (data available) is set one cycle after the fill count becomes strictly greater than the level field, which is enable bits [8 +: clog2(DEPTH)]. A count equal to the level does not set it.
- R8: Writing offset 0x30 clears each flag whose bit is 1 in the written word and leaves flags under 0 bits alone. If a flag's set condition holds in the same cycle, the flag stays set.
- R9: The interrupt line is high exactly when some flag is set and its enable bit is 1. The enable bits are bit 0 (overflow), bit 1 (packet end) and bit 4 (data available).
- R10: The enable word reads back at offset 0x2C with the layout given in R9 and R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| byte_vld | input | 1 | Encoder byte strobe |
| byte_data | input | DW | Encoder byte |
| pkt_end | input | 1 | End-of-packet pulse |
| reg_addr | input | AW | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops on data offset) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from the current address |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that a read strobe and a write strobe are never given to the data offset in the same cycle. They also assume that the register address is stable while a strobe is high, and that the encoder strobe goes high for one cycle per byte. The stimulus drives every input on the falling edge and clears it after the next rising edge, so each strobe lasts exactly one cycle. The stimulus also raises at most one register strobe per cycle.

// File: rtl/rx_fifo_irq.sv
module rx_fifo_irq #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          byte_vld,
  input  logic [DW-1:0] byte_data,
  input  logic          pkt_end,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          irq
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] OFS_DATA = AW'(8'h20);
  localparam logic [AW-1:0] OFS_EN   = AW'(8'h2C);
  localparam logic [AW-1:0] OFS_STA  = AW'(8'h30);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;
  logic [PW-1:0] lvl;
  logic en_ov, en_pe, en_av;
  logic fl_ov, fl_pe, fl_av;

  wire empty = (cnt == '0);
  wire full  = (cnt == CW'(DEPTH));
  wire pop   = reg_rd & (reg_addr == OFS_DATA) & ~empty;
  wire push  = byte_vld & ~full;
  wire drop  = byte_vld & full;
  wire sta_wr = reg_wr & (reg_addr == OFS_STA);
  wire [7:0] clr = sta_wr ? reg_wdata[7:0] : 8'h00;
  wire above = cnt > CW'(lvl);

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= byte_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (push) wptr <= (wptr == PW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (pop)  rptr <= (rptr == PW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_ov <= 1'b0;
      en_pe <= 1'b0;
      en_av <= 1'b0;
      lvl   <= '0;
    end else if (reg_wr && reg_addr == OFS_EN) begin
      en_ov <= reg_wdata[0];
      en_pe <= reg_wdata[1];
      en_av <= reg_wdata[4];
      lvl   <= reg_wdata[8 +: PW];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fl_ov <= 1'b0;
      fl_pe <= 1'b0;
      fl_av <= 1'b0;
    end else begin
      fl_ov <= drop    | (fl_ov & ~clr[0]);
      fl_pe <= pkt_end | (fl_pe & ~clr[1]);
      fl_av <= above   | (fl_av & ~clr[4]);
    end
  end

  assign irq = (fl_ov & en_ov) | (fl_pe & en_pe) | (fl_av & en_av);

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFS_DATA: reg_rdata = empty ? 32'h0 : 32'(mem[rptr]);
      OFS_EN:   reg_rdata = 32'({lvl, 3'b000, en_av, 2'b00, en_pe, en_ov});
      OFS_STA:  reg_rdata = 32'({cnt, 3'b000, fl_av, 2'b00, fl_pe, fl_ov});
      default:  reg_rdata = '0;
    endcase
  end

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  // R5
  drop_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && full && !reg_rd) |=> (cnt == CW'(DEPTH)) && fl_ov);

  // R3
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == OFS_DATA && empty && !byte_vld) |=> $stable(cnt));

  // R6
  pe_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_pe) |-> $past(pkt_end));

  // R7
  av_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt > CW'(lvl)) |=> fl_av);

  // R9
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_ov && !en_pe && !en_av) |-> !irq);
endmodule

// File: tb/rx_fifo_irq_tb.sv
module rx_fifo_irq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic byte_vld = 1'b0;
  logic [7:0] byte_data = '0;
  logic pkt_end = 1'b0;
  logic [7:0] reg_addr = '0;
  logic reg_wr = 1'b0;
  logic reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic irq;
  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  rx_fifo_irq dut_i (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_data(byte_data),
    .pkt_end(pkt_end), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  // op: 0 idle, 1 read+check, 2 write, 3 push byte, 4 packet end, 5 check irq
  // fields: {op[3:0], req[3:0], addr[7:0], data[31:0], expect[31:0]}
  localparam int NV = 18;
  localparam logic [79:0] VEC [NV] = '{
    {4'd1, 4'd1,  8'h30, 32'h0,    32'h0},     // R1 status clear
    {4'd1, 4'd1,  8'h2C, 32'h0,    32'h0},     // R1 enables clear
    {4'd5, 4'd1,  8'h00, 32'h0,    32'h0},     // R1 irq low
    {4'd2, 4'd10, 8'h2C, 32'h713,  32'h0},
    {4'd1, 4'd10, 8'h2C, 32'h0,    32'h713},   // R10 readback
    {4'd3, 4'd2,  8'h00, 32'hA1,   32'h0},
    {4'd3, 4'd2,  8'h00, 32'hB2,   32'h0},
    {4'd0, 4'd0,  8'h00, 32'h0,    32'h0},
    {4'd1, 4'd4,  8'h30, 32'h0,    32'h200},   // R4 count 2
    {4'd1, 4'd2,  8'h20, 32'h0,    32'hA1},    // R2 order
    {4'd1, 4'd2,  8'h20, 32'h0,    32'hB2},    // R2 order
    {4'd1, 4'd3,  8'h20, 32'h0,    32'h0},     // R3 empty read
    {4'd1, 4'd3,  8'h30, 32'h0,    32'h0},     // R3 count unchanged
    {4'd4, 4'd6,  8'h00, 32'h0,    32'h0},
    {4'd1, 4'd6,  8'h30, 32'h0,    32'h2},     // R6 packet end flag
    {4'd5, 4'd9,  8'h00, 32'h0,    32'h1},     // R9 irq on enabled flag
    {4'd2, 4'd8,  8'h30, 32'h2,    32'h0},
    {4'd1, 4'd8,  8'h30, 32'h0,    32'h0}      // R8 cleared
  };

  task automatic step(input int op, input logic [7:0] a, input logic [31:0] d,
                      input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_addr = a;
    case (op)
      1: reg_rd = 1'b1;
      2: begin reg_wr = 1'b1; reg_wdata = d; end
      3: begin byte_vld = 1'b1; byte_data = d[7:0]; end
      4: pkt_end = 1'b1;
      default: ;
    endcase
    #5;
    if (op == 1) begin
      n_chk++;
      if (reg_rdata !== exp) begin
        n_bad++;
        $display("FAIL %s addr %h: got %h expected %h", tag, a, reg_rdata, exp);
      end
    end else if (op == 5) begin
      n_chk++;
      if (irq !== exp[0]) begin
        n_bad++;
        $display("FAIL %s irq: got %b expected %b", tag, irq, exp[0]);
      end
    end
    @(posedge clk);
    #1;
    reg_rd = 1'b0; reg_wr = 1'b0; byte_vld = 1'b0; pkt_end = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    for (int i = 0; i < NV; i++)
      step(int'(VEC[i][79:76]), VEC[i][71:64], VEC[i][63:32], VEC[i][31:0],
           $sformatf("R%0d", VEC[i][75:72]));

    // R7: count equal to level does not set the flag
    for (int i = 0; i < 7; i++) step(3, 8'h0, 32'(8'h10 + i), 32'h0, "R7");
    step(0, 8'h0, 32'h0, 32'h0, "R7");
    step(1, 8'h30, 32'h0, 32'h700, "R7 at level");
    step(5, 8'h0, 32'h0, 32'h0, "R7 irq at level");
    step(3, 8'h0, 32'h17, 32'h0, "R7");
    step(0, 8'h0, 32'h0, 32'h0, "R7");
    step(1, 8'h30, 32'h0, 32'h810, "R7 above level");
    step(5, 8'h0, 32'h0, 32'h1, "R9 irq data avail");

    // R8: zero bits leave flags; set condition beats clear
    step(2, 8'h30, 32'h0, 32'h0, "R8");
    step(1, 8'h30, 32'h0, 32'h810, "R8 zero write");
    step(2, 8'h30, 32'h10, 32'h0, "R8");
    step(1, 8'h30, 32'h0, 32'h810, "R8 set wins");

    // R5: fill to depth, one more is dropped
    for (int i = 0; i < 9; i++) step(3, 8'h0, 32'(8'h30 + i), 32'h0, "R5");
    step(0, 8'h0, 32'h0, 32'h0, "R5");
    step(1, 8'h30, 32'h0, 32'h1011, "R5 overflow and R4 full count");

    // R9: masking by enables
    step(2, 8'h2C, 32'h700, 32'h0, "R9");
    step(5, 8'h0, 32'h0, 32'h0, "R9 all masked");
    step(2, 8'h2C, 32'h701, 32'h0, "R9");
    step(5, 8'h0, 32'h0, 32'h1, "R9 overflow enabled");

    // R2: drain in order, dropped byte absent
    for (int i = 0; i < 16; i++)
      step(1, 8'h20, 32'h0, (i < 8) ? 32'(8'h10 + i) : 32'(8'h30 + i - 8), "R2 drain");
    step(1, 8'h20, 32'h0, 32'h0, "R3 empty after drain");

    step(2, 8'h30, 32'hFF, 32'h0, "R8");
    step(0, 8'h0, 32'h0, 32'h0, "R8");
    step(1, 8'h30, 32'h0, 32'h0, "R8 clear all");
    step(5, 8'h0, 32'h0, 32'h0, "R9 irq drops");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule